// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides, for every standard-format frame a CAN receiver delivers, whether that frame is stored. An 8-bit code and an 8-bit mask held on a byte-wide CPU register bus are compared with the upper eight bits of the 11-bit identifier. A mask bit set to 1 removes its bit position from the comparison. The three lowest identifier bits never take part.

The bit engine reports the end of the identifier field, then the frame's descriptor and data bytes one at a time, and then either a good completion or an error. The block forwards the bytes of an accepted frame to the receive FIFO, but only while the FIFO reports free space. On a good completion of a fully stored frame it sets a receive-full flag. It also sets a receive interrupt flag when interrupts are enabled.

A frame that ends in error, or that loses a byte for lack of space, leaves both flags untouched. That frame's stored bytes are withdrawn with a rollback strobe. The filter registers only take CPU writes while the controller is held in reset mode.

Top module: `can_accept_filter`

## Requirements
- R1: After reset the code register reads 0x00, the mask register reads 0xFF, and rx_full and rx_irq are 0. With these values any identifier is accepted.
- R2: The code register is at address 4 and the mask register is at address 5. A CPU write to either one takes effect only while reset_mode is 1, and is ignored otherwise. A read of either one while reset_mode is 0 returns 0xFF. Read data appears on cpu_rdata one cycle after cpu_rd.
- R3: Code bit k is compared with identifier bit k+3. Identifier bits 2..0 have no effect on the decision.
- R4: A frame is accepted when every bit position k satisfies (id[k+3] XNOR code[k]) OR mask[k]. A mask bit of 1 therefore marks a position as don't-care, and a mask bit of 0 marks it as relevant.
- R5: The accept decision is taken from id_in on the cycle id_valid is 1, and it holds until the frame ends. For an accepted frame, fifo_wr is 1 together with byte_valid exactly when fifo_space is 1, with fifo_wdata equal to byte_in. A rejected frame never writes.
- R6: A frame_ok pulse that ends an accepted frame with no lost byte sets rx_full to 1 on the next cycle.
- R7: At that same completion, rx_irq is set to 1 only if irq_en is 1.
- R8: A frame ending with frame_err sets neither rx_full nor rx_irq. If the frame wrote any byte, fifo_rollback pulses for one cycle on the cycle after the end.
- R9: An accepted byte offered while fifo_space is 0 is lost. Such a frame sets no flag on frame_ok, and it is rolled back if it wrote any byte.
- R10: A read of address 3 returns {7'b0, rx_irq} and clears rx_irq. A release_cmd with fifo_will_empty set clears rx_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_mode | input | 1 | Controller held in reset mode; unlocks filter registers |
| irq_en | input | 1 | Receive interrupt enable |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Registered read data |
| id_valid | input | 1 | Identifier field complete, id_in valid |
| id_in | input | ID_W | Received identifier |
| byte_valid | input | 1 | Descriptor or data byte offered |
| byte_in | input | 8 | Descriptor or data byte |
| frame_ok | input | 1 | Frame completed without error |
| frame_err | input | 1 | Frame ended in error or was aborted |
| fifo_space | input | 1 | Receive FIFO can take a byte |
| release_cmd | input | 1 | Release-buffer command |
| fifo_will_empty | input | 1 | The current release empties the FIFO |
| fifo_wr | output | 1 | Byte write strobe to FIFO |
| fifo_wdata | output | 8 | Byte written to FIFO |
| fifo_rollback | output | 1 | Discard bytes of the current frame |
| rx_full | output | 1 | Receive-full status |
| rx_irq | output | 1 | Receive interrupt flag |

## Verification
The bench builds the block with its default parameters: an 11-bit identifier, an 8-bit comparison field and a 5-bit register address. With these values the filter-register offsets 4 and 5 and the interrupt register at 3 sit at their specified positions. The 3-bit gap between the comparison field and the identifier's LSB lets the bench flip identifier bits 2..0 and show that they have no effect. Fifo_space is controlled per byte, so partial-frame rollback can be reached as well as a frame refused at its first byte.

// File: rtl/can_acf_pkg.sv
// Shared constants and types for the CAN acceptance filter.
package can_acf_pkg;
    localparam int BYTE_W = 8;

    // Per-frame tracking state held between identifier and frame end.
    typedef struct packed {
        logic in_frame;  // between id_valid and frame end
        logic accepted;  // latched accept decision
        logic lost;      // an accepted byte met a full FIFO
        logic wrote;     // at least one byte reached the FIFO
    } frame_track_t;
endpackage

// File: rtl/can_acf_match.sv
// Identifier comparator: purely combinational.
// Assumes id_hi already holds identifier bits ID_W-1 down to ID_W-CMP_W.
module can_acf_match #(
    parameter int CMP_W = 8
) (
    input  logic [CMP_W-1:0] id_hi,
    input  logic [CMP_W-1:0] code,
    input  logic [CMP_W-1:0] mask,
    output logic             hit
);
    logic [CMP_W-1:0] bit_ok;

    // One per-bit equality-or-don't-care term for each compared position.
    for (genvar k = 0; k < CMP_W; k++) begin : g_bit
        assign bit_ok[k] = ~(id_hi[k] ^ code[k]) | mask[k];
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/can_acf_regs.sv
// Filter code/mask registers and CPU read path.
// Assumes single-cycle write and read strobes; read data is registered.
module can_acf_regs #(
    parameter int ADDR_W   = 5,
    parameter int CMP_W    = 8,
    parameter int CODE_ADR = 4,
    parameter int MASK_ADR = 5,
    parameter int IRQ_ADR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_mode,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        cpu_wdata,
    input  logic              irq_flag,
    output logic [7:0]        cpu_rdata,
    output logic              irq_clr,
    output logic [CMP_W-1:0]  code_q,
    output logic [CMP_W-1:0]  mask_q
);
    localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(CODE_ADR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADR);
    localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(IRQ_ADR);

    logic wr_ok;
    assign wr_ok   = cpu_wr & reset_mode;
    assign irq_clr = cpu_rd & (cpu_addr == A_IRQ);

    // Filter registers: updated only while the controller is in reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            mask_q <= '1;
        end else if (wr_ok) begin
            if (cpu_addr == A_CODE) code_q <= cpu_wdata[CMP_W-1:0];
            if (cpu_addr == A_MASK) mask_q <= cpu_wdata[CMP_W-1:0];
        end
    end

    // Read data register: filter registers hidden (all ones) outside reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (cpu_rd) begin
            if (cpu_addr == A_CODE)      cpu_rdata <= reset_mode ? 8'(code_q) : 8'hFF;
            else if (cpu_addr == A_MASK) cpu_rdata <= reset_mode ? 8'(mask_q) : 8'hFF;
            else if (cpu_addr == A_IRQ)  cpu_rdata <= {7'b0, irq_flag};
            else                         cpu_rdata <= '0;
        end
    end

    AST_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !reset_mode) |=> ($stable(code_q) && $stable(mask_q))); // R2
endmodule

// File: rtl/can_acf_frame.sv
// Frame tracker: gates bytes into the FIFO, raises status/interrupt on a
// good completion, and rolls back partially stored frames.
// Assumes id_valid precedes the bytes and one end pulse closes each frame.
module can_acf_frame
    import can_acf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic              id_hit,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              frame_ok,
    input  logic              frame_err,
    input  logic              fifo_space,
    input  logic              irq_en,
    input  logic              irq_clr,
    input  logic              release_cmd,
    input  logic              fifo_will_empty,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_wdata,
    output logic              fifo_rollback,
    output logic              rx_full,
    output logic              rx_irq
);
    frame_track_t trk;
    logic take_byte, drop_byte, frame_end, wrote_any, lost_any, good_end;

    assign take_byte  = trk.in_frame & trk.accepted & byte_valid;
    assign fifo_wr    = take_byte & fifo_space;
    assign drop_byte  = take_byte & ~fifo_space;
    assign fifo_wdata = byte_in;
    assign frame_end  = trk.in_frame & (frame_ok | frame_err);
    assign wrote_any  = trk.wrote | fifo_wr;
    assign lost_any   = trk.lost | drop_byte;
    assign good_end   = frame_end & frame_ok & ~frame_err & trk.accepted & ~lost_any;

    // Frame tracking: latch decision at identifier end, note writes and losses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk           <= '0;
            fifo_rollback <= 1'b0;
        end else begin
            fifo_rollback <= 1'b0;
            if (id_valid) begin
                trk <= '{in_frame: 1'b1, accepted: id_hit, lost: 1'b0, wrote: 1'b0};
            end else if (trk.in_frame) begin
                if (fifo_wr)   trk.wrote <= 1'b1;
                if (drop_byte) trk.lost  <= 1'b1;
                if (frame_end) begin
                    trk.in_frame  <= 1'b0;
                    fifo_rollback <= trk.accepted & wrote_any & (frame_err | lost_any);
                end
            end
        end
    end

    // Receive-full status: set on good completion, cleared when release empties FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n)                              rx_full <= 1'b0;
        else if (good_end)                       rx_full <= 1'b1;
        else if (release_cmd && fifo_will_empty) rx_full <= 1'b0;
    end

    // Receive interrupt flag: set on good completion when enabled, cleared by read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rx_irq <= 1'b0;
        else if (good_end && irq_en) rx_irq <= 1'b1;
        else if (irq_clr)            rx_irq <= 1'b0;
    end

    AST_STORE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_space && byte_valid)); // R5
    AST_ERR_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (trk.in_frame && frame_err && !rx_full) |=> !rx_full); // R8
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(irq_en)); // R7
    AST_ROLLBACK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rollback |-> $past(frame_ok || frame_err)); // R8
endmodule

// File: rtl/can_accept_filter.sv
// Top level of the CAN receive acceptance filter: register file, comparator
// and frame tracker. Assumes standard 11-bit identifiers only.
module can_accept_filter #(
    parameter int ID_W     = 11,
    parameter int CMP_W    = 8,
    parameter int ADDR_W   = 5,
    parameter int CODE_ADR = 4,
    parameter int MASK_ADR = 5,
    parameter int IRQ_ADR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_mode,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              id_valid,
    input  logic [ID_W-1:0]   id_in,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic              frame_ok,
    input  logic              frame_err,
    input  logic              fifo_space,
    input  logic              release_cmd,
    input  logic              fifo_will_empty,
    output logic              fifo_wr,
    output logic [7:0]        fifo_wdata,
    output logic              fifo_rollback,
    output logic              rx_full,
    output logic              rx_irq
);
    localparam int LOW_W = ID_W - CMP_W;

    logic [CMP_W-1:0] code_q, mask_q;
    logic             irq_clr, id_hit;
    logic             unused_low_id;

    assign unused_low_id = ^id_in[LOW_W-1:0];

    can_acf_regs #(
        .ADDR_W(ADDR_W), .CMP_W(CMP_W), .CODE_ADR(CODE_ADR),
        .MASK_ADR(MASK_ADR), .IRQ_ADR(IRQ_ADR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .irq_flag(rx_irq), .cpu_rdata(cpu_rdata),
        .irq_clr(irq_clr), .code_q(code_q), .mask_q(mask_q)
    );

    can_acf_match #(.CMP_W(CMP_W)) u_match (
        .id_hi(id_in[ID_W-1:LOW_W]), .code(code_q), .mask(mask_q), .hit(id_hit)
    );

    can_acf_frame u_frame (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_hit(id_hit),
        .byte_valid(byte_valid), .byte_in(byte_in), .frame_ok(frame_ok),
        .frame_err(frame_err), .fifo_space(fifo_space), .irq_en(irq_en),
        .irq_clr(irq_clr), .release_cmd(release_cmd),
        .fifo_will_empty(fifo_will_empty), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata), .fifo_rollback(fifo_rollback),
        .rx_full(rx_full), .rx_irq(rx_irq)
    );
endmodule

// File: tb/sim_can_accept_filter.sv
module sim_can_accept_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_mode = 1'b1, irq_en = 1'b0;
    logic [4:0] cpu_addr = '0;
    logic cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic id_valid = 1'b0;
    logic [10:0] id_in = '0;
    logic byte_valid = 1'b0;
    logic [7:0] byte_in = '0;
    logic frame_ok = 1'b0, frame_err = 1'b0, fifo_space = 1'b1;
    logic release_cmd = 1'b0, fifo_will_empty = 1'b0;
    logic fifo_wr, fifo_rollback, rx_full, rx_irq;
    logic [7:0] fifo_wdata;

    int vecs = 0;
    int bad = 0;

    always #4 clk = ~clk;

    can_accept_filter u0 (
        .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode), .irq_en(irq_en),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .id_valid(id_valid),
        .id_in(id_in), .byte_valid(byte_valid), .byte_in(byte_in),
        .frame_ok(frame_ok), .frame_err(frame_err), .fifo_space(fifo_space),
        .release_cmd(release_cmd), .fifo_will_empty(fifo_will_empty),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_rollback(fifo_rollback), .rx_full(rx_full), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        tick();
        cpu_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [7:0] d);
        cpu_addr = a; cpu_rd = 1'b1;
        tick();
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    // Sends one frame; space bit i gives fifo_space for byte i.
    task automatic send_frame(input logic [10:0] id, input logic [10:0] id_late,
                              input int nbytes, input logic err,
                              input logic [7:0] space, output int wrs,
                              output logic rb);
        int seen = 0;
        id_in = id; id_valid = 1'b1;
        tick();
        id_valid = 1'b0; id_in = id_late;
        for (int i = 0; i < nbytes; i++) begin
            byte_in = 8'(8'h30 + i); byte_valid = 1'b1; fifo_space = space[i];
            #1;
            if (fifo_wr) begin
                chk("R5 byte order", int'(fifo_wdata), 8'h30 + i);
                seen++;
            end
            tick();
        end
        byte_valid = 1'b0; fifo_space = 1'b1;
        if (err) frame_err = 1'b1; else frame_ok = 1'b1;
        tick();
        frame_ok = 1'b0; frame_err = 1'b0;
        rb = fifo_rollback;
        wrs = seen;
    endtask

    task automatic do_release();
        release_cmd = 1'b1; fifo_will_empty = 1'b1;
        tick();
        release_cmd = 1'b0; fifo_will_empty = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        int w; logic rb;
        reg_rd(5'd4, d); chk("R1 code reset", d, 8'h00);
        reg_rd(5'd5, d); chk("R1 mask reset", d, 8'hFF);
        chk("R1 rx_full reset", rx_full, 0);
        chk("R1 rx_irq reset", rx_irq, 0);
        send_frame(11'h5C3, 11'h5C3, 2, 1'b0, 8'hFF, w, rb);
        chk("R1 accept all", w, 2);
        chk("R6 full after good frame", rx_full, 1);
        do_release();
        chk("R10 release clears full", rx_full, 0);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        reset_mode = 1'b0;
        reg_wr(5'd4, 8'h5A);
        reg_rd(5'd4, d); chk("R2 hidden read", d, 8'hFF);
        reset_mode = 1'b1;
        reg_rd(5'd4, d); chk("R2 write ignored", d, 8'h00);
        reg_wr(5'd4, 8'hA5);
        reg_rd(5'd4, d); chk("R2 code write", d, 8'hA5);
        reg_wr(5'd5, 8'h00);
        reg_rd(5'd5, d); chk("R2 mask write", d, 8'h00);
    endtask

    task automatic t_match();
        int w; logic rb;
        send_frame({8'hA5, 3'b111}, {8'hA5, 3'b111}, 1, 1'b0, 8'hFF, w, rb);
        chk("R3 low bits set accepted", w, 1);
        send_frame({8'hA5, 3'b000}, {8'hA5, 3'b000}, 1, 1'b0, 8'hFF, w, rb);
        chk("R3 low bits clear accepted", w, 1);
        send_frame({8'hA4, 3'b101}, {8'hA4, 3'b101}, 2, 1'b0, 8'hFF, w, rb);
        chk("R4 bit0 mismatch rejected", w, 0);
        send_frame({8'h25, 3'b000}, {8'h25, 3'b000}, 2, 1'b0, 8'hFF, w, rb);
        chk("R4 bit7 mismatch rejected", w, 0);
        reg_wr(5'd5, 8'h0F);
        send_frame({8'hAF, 3'b010}, {8'hAF, 3'b010}, 1, 1'b0, 8'hFF, w, rb);
        chk("R4 masked low nibble accepted", w, 1);
        send_frame({8'h25, 3'b010}, {8'h25, 3'b010}, 1, 1'b0, 8'hFF, w, rb);
        chk("R4 relevant bit7 rejected", w, 0);
        send_frame({8'hA0, 3'b000}, {8'h00, 3'b000}, 3, 1'b0, 8'hFF, w, rb);
        chk("R5 decision latched", w, 3);
        send_frame({8'h00, 3'b000}, {8'hA0, 3'b000}, 2, 1'b0, 8'hFF, w, rb);
        chk("R5 late id ignored", w, 0);
        do_release();
    endtask

    task automatic t_status();
        logic [7:0] d;
        int w; logic rb;
        irq_en = 1'b0;
        send_frame({8'hA5, 3'b001}, {8'hA5, 3'b001}, 1, 1'b0, 8'hFF, w, rb);
        chk("R6 full set", rx_full, 1);
        chk("R7 irq masked", rx_irq, 0);
        do_release();
        chk("R10 full cleared", rx_full, 0);
        irq_en = 1'b1;
        send_frame({8'hA5, 3'b001}, {8'hA5, 3'b001}, 1, 1'b0, 8'hFF, w, rb);
        chk("R7 irq set", rx_irq, 1);
        reg_rd(5'd3, d); chk("R10 irq read value", d, 8'h01);
        chk("R10 irq cleared by read", rx_irq, 0);
        reg_rd(5'd3, d); chk("R10 irq reread", d, 8'h00);
        do_release();
    endtask

    task automatic t_error();
        int w; logic rb;
        send_frame({8'hA5, 3'b000}, {8'hA5, 3'b000}, 2, 1'b1, 8'hFF, w, rb);
        chk("R8 bytes written before error", w, 2);
        chk("R8 rollback on error", rb, 1);
        chk("R8 no full on error", rx_full, 0);
        chk("R8 no irq on error", rx_irq, 0);
        tick();
        chk("R8 rollback single pulse", fifo_rollback, 0);
        send_frame({8'hA5, 3'b000}, {8'hA5, 3'b000}, 3, 1'b0, 8'h01, w, rb);
        chk("R9 partial store count", w, 1);
        chk("R9 rollback on lost byte", rb, 1);
        chk("R9 no full on lost byte", rx_full, 0);
        send_frame({8'hA5, 3'b000}, {8'hA5, 3'b000}, 2, 1'b0, 8'h00, w, rb);
        chk("R9 no space no write", w, 0);
        chk("R9 no rollback when nothing written", rb, 0);
        chk("R9 no irq when lost", rx_irq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired before all requirements were checked");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_lock();
        t_match();
        t_status();
        t_error();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule